// File: doc/BRIEF.md
# Circular Debug Event Log with ASCII Hex Dump

This block keeps a rolling record of the last 64 event bytes, for example a state code captured each time a watched state machine moves. Each write strobe appends one byte. When the log is already full, the oldest byte is discarded to make room, so the log always holds the most recent history.

A debug push-button hold counter drives the dump request. When the count rises above a threshold, the block sends the stored bytes as printable text over a byte-wide valid/ready stream that can feed a serial transmitter directly. The text starts with a banner line, lists the entries oldest first as lowercase hex pairs, and breaks lines and groups so that the output is easy to read on a terminal. A dump only reads the log. Writes that arrive while it runs are still recorded, but they do not lengthen the dump in progress.

Top module: `trace_hexdump`

## Requirements
- R1: After a synchronous reset `tx_valid` is low and the log is empty, so a dump requested right after reset carries only the banner.
- R2: Each cycle with `log_we` high appends `log_byte` to the log, and a dump lists the entries oldest first.
- R3: The log holds 64 entries. A write to a full log discards the oldest entry and keeps 64.
- R4: Each entry is sent as its high nibble, then its low nibble, in lowercase ASCII hex (0x30-0x39 for 0-9, 0x61-0x66 for a-f), followed by one space (0x20).
- R5: After every 16th entry of a dump the block sends CR LF (0x0D 0x0A). After every 8th entry that is not a 16th it sends one extra space.
- R6: A dump starts with the six characters `TRACE:` and then CR LF. If the entry count is not a multiple of 16, the dump ends with one more CR LF.
- R7: A dump starts only when `btn_hold` is strictly greater than 100. After it starts, no new dump starts until `btn_hold` has returned to zero.
- R8: A dump leaves the log contents unchanged, so two dumps in a row with no writes between them produce identical text.
- R9: Writes made during a dump are stored. The dump in progress keeps the entry count captured when it started.
- R10: `tx_valid` and `tx_data` stay unchanged while `tx_valid` is high and `tx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| log_we | input | 1 | Write strobe: append `log_byte` this cycle |
| log_byte | input | 8 | Event byte to record |
| btn_hold | input | HOLD_W | Debug button hold count in ticks, zero when released |
| tx_ready | input | 1 | Downstream can take a character |
| tx_valid | output | 1 | Character on `tx_data` is valid |
| tx_data | output | 8 | ASCII character of the dump |

## Verification
The checker tests these properties on every cycle:
- the handshake hold rule;
- that every character sent belongs to the small set a dump can contain;
- that a dump start is a single-cycle pulse that follows a hold count above the threshold;
- that the fill count never exceeds the depth;
- that the output is idle after reset.

Only the bench scenarios can show the text as a whole: entry order, the position of grouping spaces and line breaks, the trailing line break, discarding of the oldest entry on wrap, repeat dumps, re-arming, and the count captured while writes continue.

// File: rtl/trace_hexdump_pkg.sv
package trace_hexdump_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_FETCH, ST_HI, ST_LO, ST_SEP,
    ST_GAP, ST_CR, ST_LF, ST_TCR, ST_TLF
  } emit_st_t;

  localparam logic [7:0] CH_SP = 8'h20;
  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;
  localparam int BANNER_LEN = 8;

  // lowercase hex digit for a nibble
  function automatic logic [7:0] nib2asc(input logic [3:0] n);
    if (n > 4'd9) nib2asc = 8'h57 + {4'h0, n};
    else          nib2asc = 8'h30 + {4'h0, n};
  endfunction

  // banner line: TRACE: CR LF
  function automatic logic [7:0] banner_char(input logic [2:0] i);
    case (i)
      3'd0:    banner_char = 8'h54;
      3'd1:    banner_char = 8'h52;
      3'd2:    banner_char = 8'h41;
      3'd3:    banner_char = 8'h43;
      3'd4:    banner_char = 8'h45;
      3'd5:    banner_char = 8'h3A;
      3'd6:    banner_char = CH_CR;
      default: banner_char = CH_LF;
    endcase
  endfunction

endpackage

// File: rtl/trace_trigger.sv
module trace_trigger #(
  parameter int HOLD_W      = 16,
  parameter int HOLD_THRESH = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HOLD_W-1:0] btn_hold,
  output logic              fire
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      fire    <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (btn_hold == '0) begin
        armed_q <= 1'b1;
      end else if (armed_q && (btn_hold > HOLD_W'(HOLD_THRESH))) begin
        armed_q <= 1'b0;
        fire    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_ram.sv
module trace_ram #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trace_emitter.sv
module trace_emitter
  import trace_hexdump_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_q,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data
);
  emit_st_t      st_q, after_byte;
  logic [2:0]    hdr_q;
  logic [CW-1:0] idx_q, n_q, idx_nxt;
  logic [AW-1:0] base_q;
  logic [7:0]    ch;
  logic          emitting, take;

  always_comb begin
    emitting = (st_q != ST_IDLE) && (st_q != ST_FETCH);
    take     = emitting && (!tx_valid || tx_ready);
    idx_nxt  = idx_q + 1'b1;
    if (idx_nxt != n_q)         after_byte = ST_FETCH;
    else if (n_q[3:0] != 4'h0)  after_byte = ST_TCR;
    else                        after_byte = ST_IDLE;
    case (st_q)
      ST_HDR:         ch = banner_char(hdr_q);
      ST_HI:          ch = nib2asc(rd_q[7:4]);
      ST_LO:          ch = nib2asc(rd_q[3:0]);
      ST_CR, ST_TCR:  ch = CH_CR;
      ST_LF, ST_TLF:  ch = CH_LF;
      default:        ch = CH_SP;
    endcase
    rd_en   = (st_q == ST_FETCH);
    rd_addr = base_q + idx_q[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      hdr_q    <= '0;
      idx_q    <= '0;
      n_q      <= '0;
      base_q   <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (take) begin
        tx_valid <= 1'b1;
        tx_data  <= ch;
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
      case (st_q)
        ST_IDLE: if (go) begin
          base_q <= base;
          n_q    <= count;
          hdr_q  <= '0;
          idx_q  <= '0;
          st_q   <= ST_HDR;
        end
        ST_HDR: if (take) begin
          if (hdr_q == 3'(BANNER_LEN - 1)) st_q <= (n_q == '0) ? ST_IDLE : ST_FETCH;
          else                             hdr_q <= hdr_q + 1'b1;
        end
        ST_FETCH: st_q <= ST_HI;
        ST_HI:    if (take) st_q <= ST_LO;
        ST_LO:    if (take) st_q <= ST_SEP;
        ST_SEP: if (take) begin
          if (idx_q[3:0] == 4'hF)      st_q <= ST_CR;
          else if (idx_q[2:0] == 3'h7) st_q <= ST_GAP;
          else begin
            idx_q <= idx_nxt;
            st_q  <= after_byte;
          end
        end
        ST_GAP, ST_LF: if (take) begin
          idx_q <= idx_nxt;
          st_q  <= after_byte;
        end
        ST_CR:  if (take) st_q <= ST_LF;
        ST_TCR: if (take) st_q <= ST_TLF;
        ST_TLF: if (take) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trace_hexdump.sv
module trace_hexdump #(
  parameter int DEPTH       = 64,
  parameter int HOLD_W      = 16,
  parameter int HOLD_THRESH = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              log_we,
  input  logic [7:0]        log_byte,
  input  logic [HOLD_W-1:0] btn_hold,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [AW-1:0] head_q, waddr, rd_addr;
  logic [CW-1:0] fill_q;
  logic          full, dump_go, rd_en;
  logic [7:0]    rd_q;

  // the masked sum wraps to the head itself once the log is full
  assign full  = (fill_q == CW'(DEPTH));
  assign waddr = head_q + fill_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      fill_q <= '0;
    end else if (log_we) begin
      if (full) head_q <= head_q + 1'b1;
      else      fill_q <= fill_q + 1'b1;
    end
  end

  trace_trigger #(.HOLD_W(HOLD_W), .HOLD_THRESH(HOLD_THRESH)) u_trig (
    .clk(clk), .rst(rst), .btn_hold(btn_hold), .fire(dump_go)
  );

  trace_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(log_we), .waddr(waddr), .wdata(log_byte),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_q)
  );

  trace_emitter #(.DEPTH(DEPTH)) u_emit (
    .clk(clk), .rst(rst), .go(dump_go), .base(head_q), .count(fill_q),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(rd_q),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );
endmodule

// File: rtl/trace_hexdump_chk.sv
module trace_hexdump_chk #(
  parameter int DEPTH       = 64,
  parameter int HOLD_W      = 16,
  parameter int HOLD_THRESH = 100,
  localparam int CW         = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              dump_go,
  input logic [HOLD_W-1:0] btn_hold,
  input logic [CW-1:0]     fill_q
);
  logic legal_ch;
  always_comb begin
    legal_ch = (tx_data >= 8'h30 && tx_data <= 8'h39) ||
               (tx_data >= 8'h61 && tx_data <= 8'h66) ||
               tx_data == 8'h20 || tx_data == 8'h0D || tx_data == 8'h0A ||
               tx_data == 8'h54 || tx_data == 8'h52 || tx_data == 8'h41 ||
               tx_data == 8'h43 || tx_data == 8'h45 || tx_data == 8'h3A;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) rst |=> !tx_valid);

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r4_char_set: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> legal_ch);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    dump_go |=> !dump_go);

  a_r7_above_thresh: assert property (@(posedge clk) disable iff (rst)
    $rose(dump_go) |-> ($past(btn_hold) > HOLD_W'(HOLD_THRESH)));

  a_r3_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill_q <= CW'(DEPTH));
endmodule

bind trace_hexdump trace_hexdump_chk #(
  .DEPTH(DEPTH), .HOLD_W(HOLD_W), .HOLD_THRESH(HOLD_THRESH)
) u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .dump_go(dump_go), .btn_hold(btn_hold), .fill_q(fill_q)
);

// File: tb/trace_hexdump_bench.sv
module trace_hexdump_bench;
  typedef logic [7:0] u8_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        log_we = 1'b0;
  logic [7:0]  log_byte = '0;
  logic [15:0] btn_hold = '0;
  logic        tx_ready = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;

  int n_tests = 0;
  int n_fail  = 0;
  u8_t model[$];
  string hexd = "0123456789abcdef";

  always #4 clk = ~clk;

  trace_hexdump u_trace_hexdump (
    .clk(clk), .rst(rst), .log_we(log_we), .log_byte(log_byte),
    .btn_hold(btn_hold), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  task automatic check(input bit ok, input string req, input string msg);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; log_we = 1'b0; btn_hold = '0; tx_ready = 1'b0;
    model.delete();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic log_write(input u8_t b);
    log_we = 1'b1; log_byte = b;
    if (model.size() == 64) void'(model.pop_front());
    model.push_back(b);
    @(negedge clk);
    log_we = 1'b0;
  endtask

  function automatic void build_exp(output u8_t e[$]);
    string banner = "TRACE:";
    e.delete();
    for (int i = 0; i < 6; i++) e.push_back(banner[i]);
    e.push_back(8'h0D); e.push_back(8'h0A);
    for (int i = 0; i < model.size(); i++) begin
      e.push_back(hexd[model[i][7:4]]);
      e.push_back(hexd[model[i][3:0]]);
      e.push_back(8'h20);
      if (i % 16 == 15) begin e.push_back(8'h0D); e.push_back(8'h0A); end
      else if (i % 8 == 7) e.push_back(8'h20);
    end
    if (model.size() % 16 != 0) begin e.push_back(8'h0D); e.push_back(8'h0A); end
  endfunction

  // Collect one dump and compare; bp=1 applies backpressure, inj = writes made mid-dump
  task automatic run_dump(input string req, input bit bp, input int inj, input bit release_btn);
    u8_t exp[$];
    u8_t got[$];
    int  cyc = 0, extra = 0, hold_err = 0, left = inj;
    bit  pv = 0, pr = 0;
    u8_t pd = 0;
    string m;
    build_exp(exp);
    btn_hold = 16'd150;
    while (got.size() < exp.size() && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (pv && !pr && !(tx_valid && tx_data == pd)) hold_err++;
      tx_ready = bp ? ((cyc % 3) != 0) : 1'b1;
      if (left > 0 && got.size() >= 12) begin
        log_we = 1'b1; log_byte = u8_t'(8'hC0 + left);
        if (model.size() == 64) void'(model.pop_front());
        model.push_back(log_byte);
        left--;
      end else log_we = 1'b0;
      if (tx_valid && tx_ready) got.push_back(tx_data);
      pv = tx_valid; pr = tx_ready; pd = tx_data;
    end
    log_we = 1'b0;
    tx_ready = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (tx_valid) begin extra++; got.push_back(tx_data); end
    end
    if (release_btn) btn_hold = '0;
    m = $sformatf("dump length actual %0d expected %0d", got.size(), exp.size());
    if (got.size() == exp.size()) begin
      for (int i = 0; i < exp.size(); i++)
        if (got[i] != exp[i]) begin
          m = $sformatf("char %0d actual %02h expected %02h", i, got[i], exp[i]);
          break;
        end
    end
    check(got == exp && extra == 0, req, m);
    if (bp) check(hold_err == 0, "R10",
                  $sformatf("hold violations actual %0d expected 0", hold_err));
  endtask

  task automatic count_quiet(input int cycles, input string req, input string what);
    int v = 0;
    tx_ready = 1'b1;
    repeat (cycles) begin
      @(negedge clk);
      if (tx_valid) v++;
    end
    check(v == 0, req, $sformatf("%s: valid cycles actual %0d expected 0", what, v));
  endtask

  task automatic t_reset();
    do_reset();
    check(tx_valid == 1'b0, "R1", $sformatf("tx_valid actual %0b expected 0", tx_valid));
    run_dump("R1 R6 empty log banner only", 0, 0, 1);
  endtask

  task automatic t_short();
    do_reset();
    log_write(8'h0A); log_write(8'hFF); log_write(8'h3C);
    log_write(8'h00); log_write(8'h9B);
    run_dump("R2 R4 R6 five entries", 0, 0, 1);
  endtask

  task automatic t_group();
    do_reset();
    for (int i = 0; i < 8; i++) log_write(u8_t'(8'h11 * i));
    run_dump("R5 R6 eight entries gap and tail", 0, 0, 1);
    for (int i = 0; i < 8; i++) log_write(u8_t'(8'hE0 + i));
    run_dump("R5 R6 sixteen entries no tail", 0, 0, 1);
  endtask

  task automatic t_wrap();
    do_reset();
    for (int i = 0; i < 70; i++) log_write(u8_t'(i * 7 + 3));
    check(model.size() == 64, "R3", "model depth");
    run_dump("R3 wrap drops oldest", 0, 0, 1);
  endtask

  task automatic t_backpressure();
    do_reset();
    for (int i = 0; i < 37; i++) log_write(u8_t'(8'hA5 ^ i));
    run_dump("R10 R2 under backpressure", 1, 0, 1);
    repeat (3) @(negedge clk);
    run_dump("R8 repeat dump identical", 0, 0, 1);
  endtask

  task automatic t_trigger();
    do_reset();
    log_write(8'h42); log_write(8'h7E); log_write(8'hD1);
    run_dump("R7 first dump", 0, 0, 0);
    count_quiet(60, "R7", "held button retriggered");
    btn_hold = '0;
    repeat (2) @(negedge clk);
    btn_hold = 16'd100;
    count_quiet(60, "R7", "count of exactly 100 triggered");
    run_dump("R7 count 101 and above rearmed", 0, 0, 1);
  endtask

  task automatic t_mid_write();
    do_reset();
    for (int i = 0; i < 10; i++) log_write(u8_t'(8'h20 + i));
    run_dump("R9 dump length latched", 0, 3, 1);
    check(model.size() == 13, "R9", "model size after mid-dump writes");
    repeat (2) @(negedge clk);
    run_dump("R9 later writes stored", 0, 0, 1);
  endtask

  bit done = 0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_short();
    t_group();
    t_wrap();
    t_backpressure();
    t_trigger();
    t_mid_write();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule